// File: doc/BRIEF.md
# DMA Channel Register File with Interrupt Status

This block is the software-visible register file of a multi-channel DMA controller. It stores one global configuration word and a sync word, plus five words for each channel: source address, destination address, next-descriptor link, transfer control and channel configuration. It keeps one raw terminal-count bit and one raw error bit per channel. From these it derives masked status words and a single interrupt line. The channel count is a parameter and may be 8 or 2.

Software reaches the block through a word-addressed 32-bit register port. The port has a 12-bit byte address, a write enable, write data and combinational read data. The transfer engine sits outside this block. It reports a finished transfer on the `chDone` pulse input and a failed transfer on the `chErr` pulse input, one bit per channel. Each channel's interrupt enables are taken from two bits of that channel's configuration word, so no separate mask register exists.

Top module: `dma_regbank`

## Requirements
- R1: After reset every register and every raw interrupt bit is 0, `irqOut` and `dmaEnable` are low, and every readable offset returns 0.
- R2: The words of channel n are at 0x100 + 0x20*n: source +0x00, destination +0x04, link +0x08, control +0x0C, configuration +0x10. Each reads back the full 32-bit value last written to it.
- R3: The global configuration word at 0x30 and the sync word at 0x34 read back what was written. Bit 0 of the global word drives `dmaEnable`.
- R4: Bit 15 of a channel's configuration enables that channel's terminal-count interrupt, and bit 14 enables its error interrupt. Offset 0x04 reads the enabled terminal-count bits, 0x0C reads the enabled error bits, and 0x00 reads the OR of the two. Channel n sits in bit n.
- R5: A high `chDone[n]` sets raw terminal-count bit n on the next clock, and a high `chErr[n]` sets raw error bit n. The raw bits read at 0x14 (terminal count) and 0x18 (error).
- R6: A write to 0x08 clears every raw terminal-count bit whose write-data bit is 1. A write to 0x10 does the same for the raw error bits. Bits written as 0 keep their value.
- R7: When a set pulse and a clear write hit the same raw bit in the same cycle, the bit ends up set.
- R8: `irqOut` is high exactly when some raw bit has its matching enable set.
- R9: Offset 0x1C reads a bitmap holding bit 0 of each channel's configuration word.
- R10: Word i (0 to 7) of the window 0xFE0 to 0xFFC reads an identification byte in this order: 0x80 (0x81 when there are 2 channels), 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1.
- R11: Undefined offsets read 0 and writes to them change nothing. This covers a channel index at or above the channel count and channel offsets +0x14 to +0x1C.
- R12: The software request offsets 0x20, 0x24, 0x28 and 0x2C read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| regAddr | input | 12 | Byte address of the register access; bits 1:0 are ignored |
| regWe | input | 1 | Write strobe for the current cycle |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| chDone | input | NUM_CH | Per-channel terminal-count set pulses |
| chErr | input | NUM_CH | Per-channel error set pulses |
| irqOut | output | 1 | Combined interrupt, high while any enabled raw bit is set |
| dmaEnable | output | 1 | Controller enable, bit 0 of the global configuration |

## Verification
A completion pulse from a channel can arrive in the same cycle as a software write that clears that channel's raw bit. The bench drives `chDone` and a write of all ones to 0x08 in one cycle. It then expects the pulsed bit to stay set while every other pending bit is cleared. The error path gets the same treatment with 0x10 and `chErr`. A behavioural model predicts the read data, `irqOut` and `dmaEnable` every clock, so each overlap is judged on the very next cycle.

// File: rtl/dma_regbank_pkg.sv
package dma_regbank_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 3;

  typedef enum logic [3:0] {
    RD_NONE, RD_IRQ, RD_TCM, RD_ERRM, RD_TCRAW, RD_ERRRAW,
    RD_ENMAP, RD_GCFG, RD_SYNC, RD_CHAN, RD_ID
  } rdSel_e;

  typedef struct packed {
    logic             wrChan;
    logic [IDX_W-1:0] chIdx;
    logic [2:0]       chReg;
    logic             wrGcfg;
    logic             wrSync;
    logic             clrTc;
    logic             clrErr;
    rdSel_e           rdSel;
    logic [2:0]       idIdx;
  } regStrobe_t;
endpackage

// File: rtl/dma_regbank_ctrl.sv
module dma_regbank_ctrl
  import dma_regbank_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  output regStrobe_t        strb
);
  localparam logic [2:0] LAST_CH_REG = 3'd4;

  logic [IDX_W-1:0] idx;
  logic [2:0]       sub;
  logic [9:0]       word;

  assign idx  = regAddr[7:5];
  assign sub  = regAddr[4:2];
  assign word = regAddr[ADDR_W-1:2];

  always_comb begin
    strb = '0;
    strb.rdSel = RD_NONE;
    strb.chIdx = idx;
    strb.chReg = sub;
    strb.idIdx = sub;
    if (regAddr[11:8] == 4'h1) begin
      if ((int'(idx) < NUM_CH) && (sub <= LAST_CH_REG)) begin
        strb.rdSel  = RD_CHAN;
        strb.wrChan = regWe;
      end
    end else if (regAddr[11:5] == 7'h7F) begin
      strb.rdSel = RD_ID;
    end else begin
      case (word)
        10'h000: strb.rdSel = RD_IRQ;
        10'h001: strb.rdSel = RD_TCM;
        10'h002: strb.clrTc = regWe;
        10'h003: strb.rdSel = RD_ERRM;
        10'h004: strb.clrErr = regWe;
        10'h005: strb.rdSel = RD_TCRAW;
        10'h006: strb.rdSel = RD_ERRRAW;
        10'h007: strb.rdSel = RD_ENMAP;
        10'h00C: begin strb.rdSel = RD_GCFG; strb.wrGcfg = regWe; end
        10'h00D: begin strb.rdSel = RD_SYNC; strb.wrSync = regWe; end
        default: strb.rdSel = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/dma_regbank_data.sv
module dma_regbank_data
  import dma_regbank_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [NUM_CH-1:0] chDone,
  input  logic [NUM_CH-1:0] chErr,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqOut,
  output logic              dmaEnable,
  output logic [NUM_CH-1:0] rawTc,
  output logic [NUM_CH-1:0] rawErr
);
  localparam int PAD_W   = DATA_W - NUM_CH;
  localparam int TC_EN   = 15;
  localparam int ERR_EN  = 14;
  localparam int CH_ON   = 0;

  logic [DATA_W-1:0] chSrc  [NUM_CH];
  logic [DATA_W-1:0] chDst  [NUM_CH];
  logic [DATA_W-1:0] chLink [NUM_CH];
  logic [DATA_W-1:0] chCtl  [NUM_CH];
  logic [DATA_W-1:0] chCfg  [NUM_CH];
  logic [DATA_W-1:0] gCfg, syncWord;
  logic [NUM_CH-1:0] tcMask, errMask, enMap, tcMasked, errMasked;
  logic [NUM_CH-1:0] clrTcVec, clrErrVec;
  logic [DATA_W-1:0] chWord;
  logic [7:0]        idByte;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rstN) begin
        chSrc[n] <= '0; chDst[n] <= '0; chLink[n] <= '0;
        chCtl[n] <= '0; chCfg[n] <= '0;
      end else if (strb.wrChan && (int'(strb.chIdx) == n)) begin
        case (strb.chReg)
          3'd0: chSrc[n]  <= regWdata;
          3'd1: chDst[n]  <= regWdata;
          3'd2: chLink[n] <= regWdata;
          3'd3: chCtl[n]  <= regWdata;
          3'd4: chCfg[n]  <= regWdata;
          default: ;
        endcase
      end
    end
    assign tcMask[n]  = chCfg[n][TC_EN];
    assign errMask[n] = chCfg[n][ERR_EN];
    assign enMap[n]   = chCfg[n][CH_ON];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gCfg <= '0;
      syncWord <= '0;
    end else begin
      if (strb.wrGcfg) gCfg <= regWdata;
      if (strb.wrSync) syncWord <= regWdata;
    end
  end

  // set pulses are ORed in after the clear, so a coinciding set survives
  assign clrTcVec  = strb.clrTc  ? regWdata[NUM_CH-1:0] : '0;
  assign clrErrVec = strb.clrErr ? regWdata[NUM_CH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawTc  <= '0;
      rawErr <= '0;
    end else begin
      rawTc  <= (rawTc  & ~clrTcVec)  | chDone;
      rawErr <= (rawErr & ~clrErrVec) | chErr;
    end
  end

  assign tcMasked  = rawTc & tcMask;
  assign errMasked = rawErr & errMask;
  assign irqOut    = |{tcMasked, errMasked};
  assign dmaEnable = gCfg[0];

  always_comb begin
    chWord = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      if (int'(strb.chIdx) == n) begin
        case (strb.chReg)
          3'd0: chWord = chSrc[n];
          3'd1: chWord = chDst[n];
          3'd2: chWord = chLink[n];
          3'd3: chWord = chCtl[n];
          3'd4: chWord = chCfg[n];
          default: chWord = '0;
        endcase
      end
    end
  end

  always_comb begin
    case (strb.idIdx)
      3'd0: idByte = (NUM_CH == 8) ? 8'h80 : 8'h81;
      3'd1: idByte = 8'h10;
      3'd2: idByte = 8'h04;
      3'd3: idByte = 8'h0A;
      3'd4: idByte = 8'h0D;
      3'd5: idByte = 8'hF0;
      3'd6: idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  end

  always_comb begin
    case (strb.rdSel)
      RD_IRQ:    regRdata = {{PAD_W{1'b0}}, tcMasked | errMasked};
      RD_TCM:    regRdata = {{PAD_W{1'b0}}, tcMasked};
      RD_ERRM:   regRdata = {{PAD_W{1'b0}}, errMasked};
      RD_TCRAW:  regRdata = {{PAD_W{1'b0}}, rawTc};
      RD_ERRRAW: regRdata = {{PAD_W{1'b0}}, rawErr};
      RD_ENMAP:  regRdata = {{PAD_W{1'b0}}, enMap};
      RD_GCFG:   regRdata = gCfg;
      RD_SYNC:   regRdata = syncWord;
      RD_CHAN:   regRdata = chWord;
      RD_ID:     regRdata = {24'h0, idByte};
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
  import dma_regbank_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [11:0]       regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [NUM_CH-1:0] chDone,
  input  logic [NUM_CH-1:0] chErr,
  output logic              irqOut,
  output logic              dmaEnable
);
  regStrobe_t        strb;
  logic [NUM_CH-1:0] rawTc, rawErr;

  dma_regbank_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .regAddr(regAddr), .regWe(regWe), .strb(strb)
  );

  dma_regbank_data #(.NUM_CH(NUM_CH)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .regWdata(regWdata),
    .chDone(chDone), .chErr(chErr), .regRdata(regRdata),
    .irqOut(irqOut), .dmaEnable(dmaEnable), .rawTc(rawTc), .rawErr(rawErr)
  );
endmodule

// File: rtl/dma_regbank_checker.sv
module dma_regbank_checker #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [11:0]       regAddr,
  input logic              regWe,
  input logic [31:0]       regWdata,
  input logic [31:0]       regRdata,
  input logic [NUM_CH-1:0] chDone,
  input logic [NUM_CH-1:0] chErr,
  input logic              irqOut,
  input logic              dmaEnable,
  input logic [NUM_CH-1:0] rawTc,
  input logic [NUM_CH-1:0] rawErr
);
  assert_done_sets_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|chDone) |=> ((rawTc & $past(chDone)) == $past(chDone)));

  assert_err_sets_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|chErr) |=> ((rawErr & $past(chErr)) == $past(chErr)));

  // R6 with R7: only bits pulsed in the same cycle may survive a clear
  assert_tc_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr[11:2] == 10'h002) |=>
      ((rawTc & $past(regWdata[NUM_CH-1:0]) & ~$past(chDone)) == '0));

  assert_raw_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!regWe && chDone == '0 && chErr == '0) |=>
      (rawTc == $past(rawTc) && rawErr == $past(rawErr)));

  assert_quiet_irq_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rawTc == '0 && rawErr == '0) |-> !irqOut);

  assert_hole_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr >= 12'h200 && regAddr < 12'hFE0) |-> (regRdata == 32'h0));

  assert_enable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr[11:2] == 10'h00C) |=> (dmaEnable == $past(regWdata[0])));
endmodule

bind dma_regbank dma_regbank_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
  .regWdata(regWdata), .regRdata(regRdata), .chDone(chDone), .chErr(chErr),
  .irqOut(irqOut), .dmaEnable(dmaEnable), .rawTc(rawTc), .rawErr(rawErr)
);

// File: tb/test_dma_regbank.sv
`timescale 1ns/1ps
module test_dma_regbank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [7:0]  chDone = '0;
  logic [7:0]  chErr = '0;
  logic [31:0] regRdata, rd2;
  logic        irqOut, dmaEnable, irq2, en2;

  int    nTests = 0;
  int    nFails = 0;
  int    cycles = 0;
  string curReq = "R1";

  always #4 clk = ~clk;

  dma_regbank #(.NUM_CH(8)) i_dma_regbank (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .chDone(chDone),
    .chErr(chErr), .irqOut(irqOut), .dmaEnable(dmaEnable)
  );

  dma_regbank #(.NUM_CH(2)) i_dma_regbank_two (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(rd2), .chDone(chDone[1:0]),
    .chErr(chErr[1:0]), .irqOut(irq2), .dmaEnable(en2)
  );

  // behavioural reference for the 8-channel instance
  int unsigned mCh[8][5];
  int unsigned mGcfg, mSync, mTc, mErr;
  int unsigned idList[8] = '{32'h80, 32'h10, 32'h04, 32'h0A,
                             32'h0D, 32'hF0, 32'h05, 32'hB1};

  function automatic int unsigned mTcMask();
    int unsigned m = 0;
    for (int c = 0; c < 8; c++) if (mCh[c][4][15]) m |= (1 << c);
    return m;
  endfunction

  function automatic int unsigned mErrMask();
    int unsigned m = 0;
    for (int c = 0; c < 8; c++) if (mCh[c][4][14]) m |= (1 << c);
    return m;
  endfunction

  function automatic int unsigned mRead(int unsigned a);
    int unsigned w = a & 32'hFFC;
    int unsigned m = 0;
    if (w >= 32'h100 && w < 32'h200) begin
      if (((w - 32'h100) % 32) / 4 <= 4) return mCh[(w - 32'h100) / 32][((w - 32'h100) % 32) / 4];
      return 0;
    end
    if (w >= 32'hFE0) return idList[(w - 32'hFE0) / 4];
    case (w)
      32'h00: return (mTc & mTcMask()) | (mErr & mErrMask());
      32'h04: return mTc & mTcMask();
      32'h0C: return mErr & mErrMask();
      32'h14: return mTc;
      32'h18: return mErr;
      32'h1C: begin
        for (int c = 0; c < 8; c++) if (mCh[c][4][0]) m |= (1 << c);
        return m;
      end
      32'h30: return mGcfg;
      32'h34: return mSync;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < 8; c++) for (int r = 0; r < 5; r++) mCh[c][r] = 0;
      mGcfg = 0; mSync = 0; mTc = 0; mErr = 0;
    end else begin
      int unsigned w;
      int unsigned clrT, clrE;
      w = regAddr & 12'hFFC;
      clrT = 0; clrE = 0;
      if (regWe) begin
        if (w >= 32'h100 && w < 32'h200 && ((w - 32'h100) % 32) / 4 <= 4)
          mCh[(w - 32'h100) / 32][((w - 32'h100) % 32) / 4] = regWdata;
        else if (w == 32'h30) mGcfg = regWdata;
        else if (w == 32'h34) mSync = regWdata;
        else if (w == 32'h08) clrT = regWdata & 32'hFF;
        else if (w == 32'h10) clrE = regWdata & 32'hFF;
      end
      mTc  = (mTc & ~clrT) | chDone;
      mErr = (mErr & ~clrE) | chErr;
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nTests++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      check(curReq, regRdata, mRead(regAddr));
      check("R8", {31'h0, irqOut}, {31'h0, ((mTc & mTcMask()) | (mErr & mErrMask())) != 0});
      check("R3", {31'h0, dmaEnable}, {31'h0, mGcfg[0]});
    end
  end

  task automatic step(input logic [11:0] a, input logic we, input logic [31:0] d,
                      input logic [7:0] dn, input logic [7:0] er, input string req);
    @(posedge clk); #2;
    curReq = req; regAddr = a; regWe = we; regWdata = d; chDone = dn; chErr = er;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string req);
    step(a, 1'b1, d, 8'h0, 8'h0, req);
  endtask

  task automatic rdExp(input logic [11:0] a, input logic [31:0] exp, input string req);
    step(a, 1'b0, 32'h0, 8'h0, 8'h0, req);
    @(negedge clk);
    check(req, regRdata, exp);
  endtask

  task automatic rd2Exp(input logic [11:0] a, input logic [31:0] exp, input string req);
    step(a, 1'b0, 32'h0, 8'h0, 8'h0, req);
    @(negedge clk);
    check(req, rd2, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    // R1: reset state
    rdExp(12'h000, 32'h0, "R1");
    rdExp(12'h014, 32'h0, "R1");
    rdExp(12'h110, 32'h0, "R1");
    check("R1", {30'h0, irqOut, dmaEnable}, 32'h0);

    // R2: channel words for channel 0 and channel 7
    wr(12'h100, 32'h1111_0000, "R2");
    wr(12'h104, 32'h2222_0004, "R2");
    wr(12'h108, 32'h3333_0008, "R2");
    wr(12'h10C, 32'h4444_000C, "R2");
    wr(12'h110, 32'h0001_0000, "R2");
    wr(12'h1E0, 32'hDEAD_BEEF, "R2");
    wr(12'h1F0, 32'h0000_0001, "R2");
    rdExp(12'h100, 32'h1111_0000, "R2");
    rdExp(12'h108, 32'h3333_0008, "R2");
    rdExp(12'h10C, 32'h4444_000C, "R2");
    rdExp(12'h1E0, 32'hDEAD_BEEF, "R2");

    // R3: global configuration and sync
    wr(12'h030, 32'h0000_0001, "R3");
    rdExp(12'h030, 32'h0000_0001, "R3");
    check("R3", {31'h0, dmaEnable}, 32'h1);
    wr(12'h034, 32'h0000_ABCD, "R3");
    rdExp(12'h034, 32'h0000_ABCD, "R3");

    // R9: enable bitmap
    wr(12'h150, 32'h0000_8001, "R4");
    wr(12'h1B0, 32'h0000_4000, "R4");
    rdExp(12'h01C, 32'h0000_0084 | 32'h4, "R9");

    // R5 and R4: terminal-count pulses on channels 2 and 5
    step(12'h014, 1'b0, 32'h0, 8'h24, 8'h00, "R5");
    rdExp(12'h014, 32'h24, "R5");
    rdExp(12'h004, 32'h04, "R4");
    check("R8", {31'h0, irqOut}, 32'h1);
    step(12'h018, 1'b0, 32'h0, 8'h00, 8'h20, "R5");
    rdExp(12'h018, 32'h20, "R5");
    rdExp(12'h00C, 32'h20, "R4");
    rdExp(12'h000, 32'h24, "R4");

    // R6: write-one-to-clear
    wr(12'h008, 32'h0000_0004, "R6");
    rdExp(12'h014, 32'h20, "R6");
    check("R8", {31'h0, irqOut}, 32'h1);
    wr(12'h010, 32'h0000_0020, "R6");
    rdExp(12'h018, 32'h0, "R6");
    check("R8", {31'h0, irqOut}, 32'h0);

    // R7: set and clear on the same bit in one cycle
    step(12'h008, 1'b1, 32'hFFFF_FFFF, 8'h04, 8'h00, "R7");
    rdExp(12'h014, 32'h04, "R7");
    check("R8", {31'h0, irqOut}, 32'h1);
    step(12'h010, 1'b1, 32'hFFFF_FFFF, 8'h00, 8'h20, "R7");
    rdExp(12'h018, 32'h20, "R7");

    // R12: software request offsets
    wr(12'h024, 32'hFFFF_FFFF, "R12");
    rdExp(12'h024, 32'h0, "R12");
    rdExp(12'h02C, 32'h0, "R12");
    rdExp(12'h014, 32'h04, "R12");
    rdExp(12'h034, 32'h0000_ABCD, "R12");

    // R11: undefined offsets
    wr(12'h114, 32'h5555_5555, "R11");
    rdExp(12'h114, 32'h0, "R11");
    rdExp(12'h110, 32'h0001_0000, "R11");
    rdExp(12'h040, 32'h0, "R11");
    wr(12'h500, 32'h7777_7777, "R11");
    rdExp(12'h500, 32'h0, "R11");

    // R10: identification bytes
    for (int i = 0; i < 8; i++) rdExp(12'hFE0 + 12'(4 * i), idList[i], "R10");
    rd2Exp(12'hFE0, 32'h81, "R10");
    rd2Exp(12'hFFC, 32'hB1, "R10");

    // R11: channel index beyond the 2-channel count
    wr(12'h140, 32'h1234_5678, "R11");
    rd2Exp(12'h140, 32'h0, "R11");
    rd2Exp(12'h120, 32'h0, "R11");

    step(12'h000, 1'b0, 32'h0, 8'h0, 8'h0, "R4");
    repeat (2) @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    nTests++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule